// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block turns 32-bit virtual addresses into physical addresses through a 32-entry fully associative translation buffer. It also carries out the buffer management operations that a CPU controller issues. Pages are 4 KiB. Each entry holds a 20-bit virtual page tag and, in a synchronous frame memory, a 20-bit frame number with a valid bit and a writable bit. All 32 tags are compared with the page number in parallel. A priority encoder picks the lowest-numbered matching entry.

The controller selects one operation per cycle on a 3-bit function code. A map request delivers its physical address and status one clock later, and the block then holds that result until the next map. The status reports a miss, split into kernel and user, an invalid entry, or a write-protected page. The block exchanges values with three special registers held outside it: index, entry-high and entry-low. It sees the current value of each one and can request a write with its own enable and new value. Search, indexed read, indexed write and random write all use these registers. The random victim comes from a down-counter that moves only on map requests.

Top module: `tlb_mmu`

## Requirements
- R1: While reset is held and right after it, paddr_o is 0, all four status flags are 0 and no register write enable is set. The random victim counter restarts at entry 31.
- R2: Function codes are 0 nop, 1 map, 2 search, 3 write-random, 4 read-indexed and 5 write-indexed. In the cycle after a map of an address whose top two bits are not 11 that hits, paddr_o is {frame, vaddr[11:0]}. Entry-low bits 31:12 hold the frame, bit 1 is writable and bit 0 is valid. invalid_o is the inverse of valid. wprot_o is set only for a valid entry that is not writable.
- R3: In the cycle after a map that misses, paddr_o is 0 and invalid_o and wprot_o are 0. miss_kern_o is set if vaddr bit 31 was 1, otherwise miss_user_o is set. At most one status flag is ever set.
- R4: A map of an address whose bits 31:30 are both 1 bypasses the buffer. One cycle later paddr_o is the address with those two bits cleared, and all status flags are 0.
- R5: When several entries carry the same tag, the lowest-numbered one wins, for both map and search.
- R6: paddr_o and the status flags change only in the cycle after a map. At all other times they hold the last result, even if inputs change or entries are rewritten.
- R7: Search compares entry-high bits 31:12 with the tags. In the same cycle it sets idx_we_o, with idx_new_o equal to the matching entry number, or 0x8000_0000 if nothing matches.
- R8: Write-indexed loads the entry numbered by index bits 4:0 at the clock edge. The tag comes from entry-high bits 31:12, and the frame, writable and valid bits come from entry-low.
- R9: Write-random loads the entry chosen by the victim counter. The counter starts at 31 and steps down once per map request, including bypassed ones. After 4 it goes back to 31. No other function moves it.
- R10: Read-indexed sets ehi_we_o and elo_we_o in the same cycle. ehi_new_o is {tag, 12'b0} and elo_new_o is {frame, 10'b0, writable, valid} of the entry at index bits 4:0. This holds when the index was already present in the preceding cycle and that cycle was neither a map nor a write.
- R11: Codes 6 and 7 act as nop. Only search and read-indexed ever raise a register write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fn_i | input | 3 | Function code for this cycle |
| vaddr_i | input | 32 | Virtual address for map |
| paddr_o | output | 32 | Physical address result |
| miss_kern_o | output | 1 | No entry matched, address bit 31 set |
| miss_user_o | output | 1 | No entry matched, address bit 31 clear |
| invalid_o | output | 1 | Matching entry not valid |
| wprot_o | output | 1 | Matching entry valid but not writable |
| idx_old_i | input | 32 | Current index register |
| idx_we_o | output | 1 | Write enable for index register |
| idx_new_o | output | 32 | New index value |
| ehi_old_i | input | 32 | Current entry-high register |
| ehi_we_o | output | 1 | Write enable for entry-high register |
| ehi_new_o | output | 32 | New entry-high value |
| elo_old_i | input | 32 | Current entry-low register |
| elo_we_o | output | 1 | Write enable for entry-low register |
| elo_new_o | output | 32 | New entry-low value |

## Verification
Map results appear exactly one clock after the map request, because the frame memory read and the delayed miss flag both add one register. The bench therefore drives a map on a falling edge, drives the following cycle, and samples shortly after the next falling edge. Register write requests from search and read-indexed are combinational in the same cycle, so they are sampled two nanoseconds after the function is driven, before the next rising edge. Entry writes take effect at the rising edge that ends their cycle, so they are observed through a later map, search or read.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned PAGE_BITS = 12;
  localparam int unsigned FRAME_W   = ADDR_W - PAGE_BITS;

  typedef enum logic [2:0] {
    FN_NOP     = 3'd0,
    FN_MAP     = 3'd1,
    FN_SEARCH  = 3'd2,
    FN_WR_RAND = 3'd3,
    FN_RD_IDX  = 3'd4,
    FN_WR_IDX  = 3'd5
  } tlb_fn_e;

  typedef struct packed {
    logic [FRAME_W-1:0] frame;
    logic               wr;
    logic               vld;
  } frame_ent_t;

  function automatic logic [FRAME_W-1:0] vpn_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:PAGE_BITS];
  endfunction

  function automatic logic is_direct(input logic [ADDR_W-1:0] a);
    return &a[ADDR_W-1:ADDR_W-2];
  endfunction

  function automatic logic [ADDR_W-1:0] direct_pa(input logic [ADDR_W-1:0] a);
    return {2'b00, a[ADDR_W-3:0]};
  endfunction

  function automatic frame_ent_t ent_from_lo(input logic [ADDR_W-1:0] lo);
    frame_ent_t e;
    e.frame = lo[ADDR_W-1:PAGE_BITS];
    e.wr    = lo[1];
    e.vld   = lo[0];
    return e;
  endfunction

  function automatic logic [ADDR_W-1:0] lo_from_ent(input frame_ent_t e);
    return {e.frame, {(PAGE_BITS-2){1'b0}}, e.wr, e.vld};
  endfunction

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [FRAME_W-1:0] wr_vpn,
  input  logic [FRAME_W-1:0] key_vpn,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx,
  output logic [FRAME_W-1:0] rd_vpn
);

  logic [FRAME_W-1:0] tag_q [ENTRIES];
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        tag_q[g] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(g)))
        tag_q[g] <= wr_vpn;
    end
    assign match[g] = (tag_q[g] == key_vpn);
  end

  // lowest-numbered match wins
  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit    = |match;
  assign rd_vpn = tag_q[rd_idx];

endmodule

// File: rtl/tlb_frame_ram.sv
module tlb_frame_ram
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  frame_ent_t       wdata,
  input  logic [IDX_W-1:0] raddr,
  output frame_ent_t       rdata
);

  frame_ent_t mem [ENTRIES];
  frame_ent_t rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/tlb_victim_ctr.sv
module tlb_victim_ctr #(
  parameter int unsigned ENTRIES  = 32,
  parameter int unsigned IDX_W    = $clog2(ENTRIES),
  parameter int unsigned RAND_LOW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [IDX_W-1:0] victim
);

  function automatic logic [IDX_W-1:0] next_victim(input logic [IDX_W-1:0] cur);
    if (cur == IDX_W'(RAND_LOW)) return IDX_W'(ENTRIES - 1);
    return cur - 1'b1;
  endfunction

  logic [IDX_W-1:0] victim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    victim_q <= IDX_W'(ENTRIES - 1);
    else if (step) victim_q <= next_victim(victim_q);
  end

  assign victim = victim_q;

endmodule

// File: rtl/tlb_mmu.sv
module tlb_mmu
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES  = 32,
  parameter int unsigned RAND_LOW = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  fn_i,
  input  logic [31:0] vaddr_i,
  output logic [31:0] paddr_o,
  output logic        miss_kern_o,
  output logic        miss_user_o,
  output logic        invalid_o,
  output logic        wprot_o,
  input  logic [31:0] idx_old_i,
  output logic        idx_we_o,
  output logic [31:0] idx_new_o,
  input  logic [31:0] ehi_old_i,
  output logic        ehi_we_o,
  output logic [31:0] ehi_new_o,
  input  logic [31:0] elo_old_i,
  output logic        elo_we_o,
  output logic [31:0] elo_new_o
);

  localparam int unsigned IDX_W = $clog2(ENTRIES);

  // decoded function strobes
  logic is_map, is_search, is_wr_rand, is_rd_idx, is_wr_idx;
  assign is_map     = (fn_i == FN_MAP);
  assign is_search  = (fn_i == FN_SEARCH);
  assign is_wr_rand = (fn_i == FN_WR_RAND);
  assign is_rd_idx  = (fn_i == FN_RD_IDX);
  assign is_wr_idx  = (fn_i == FN_WR_IDX);

  // named internal events
  logic               ent_write;
  logic [IDX_W-1:0]   ent_widx;
  logic [IDX_W-1:0]   reg_idx;
  logic [IDX_W-1:0]   victim_idx;
  logic [FRAME_W-1:0] key_vpn;
  logic               cam_hit;
  logic [IDX_W-1:0]   cam_idx;
  logic [FRAME_W-1:0] rd_vpn;
  logic [IDX_W-1:0]   ram_raddr;
  frame_ent_t         ram_rd;

  assign reg_idx   = idx_old_i[IDX_W-1:0];
  assign ent_write = is_wr_rand | is_wr_idx;
  assign ent_widx  = is_wr_rand ? victim_idx : reg_idx;
  assign key_vpn   = is_search ? vpn_of(ehi_old_i) : vpn_of(vaddr_i);
  assign ram_raddr = is_map ? cam_idx : reg_idx;

  logic unused_bits;
  assign unused_bits = ^{idx_old_i[31:IDX_W], ehi_old_i[PAGE_BITS-1:0],
                         elo_old_i[PAGE_BITS-1:2]};

  tlb_cam #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_cam (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ent_write),
    .wr_idx  (ent_widx),
    .wr_vpn  (vpn_of(ehi_old_i)),
    .key_vpn (key_vpn),
    .rd_idx  (reg_idx),
    .hit     (cam_hit),
    .hit_idx (cam_idx),
    .rd_vpn  (rd_vpn)
  );

  tlb_frame_ram #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ram (
    .clk   (clk),
    .we    (ent_write),
    .waddr (ent_widx),
    .wdata (ent_from_lo(elo_old_i)),
    .raddr (ram_raddr),
    .rdata (ram_rd)
  );

  tlb_victim_ctr #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .RAND_LOW(RAND_LOW)) u_victim (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (is_map),
    .victim (victim_idx)
  );

  // map pipeline: request captured, miss delayed to line up with frame read
  logic        map_q;
  logic [31:0] va_q;
  logic        miss_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q  <= 1'b0;
      va_q   <= '0;
      miss_q <= 1'b0;
    end else begin
      map_q <= is_map;
      if (is_map) begin
        va_q   <= vaddr_i;
        miss_q <= ~cam_hit;
      end
    end
  end

  logic        live_direct;
  logic [31:0] live_pa;
  logic [3:0]  live_flags;   // {kern miss, user miss, invalid, write protect}

  assign live_direct = is_direct(va_q);

  always_comb begin
    if (live_direct) begin
      live_pa    = direct_pa(va_q);
      live_flags = 4'b0000;
    end else if (miss_q) begin
      live_pa    = '0;
      live_flags = {va_q[31], ~va_q[31], 2'b00};
    end else begin
      live_pa    = {ram_rd.frame, va_q[PAGE_BITS-1:0]};
      live_flags = {2'b00, ~ram_rd.vld, ram_rd.vld & ~ram_rd.wr};
    end
  end

  // hold register keeps the last result between map requests
  logic [31:0] held_pa;
  logic [3:0]  held_flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_pa    <= '0;
      held_flags <= '0;
    end else if (map_q) begin
      held_pa    <= live_pa;
      held_flags <= live_flags;
    end
  end

  assign paddr_o = map_q ? live_pa : held_pa;
  assign {miss_kern_o, miss_user_o, invalid_o, wprot_o} = map_q ? live_flags : held_flags;

  // special register triplets
  assign idx_we_o  = is_search;
  assign idx_new_o = cam_hit ? 32'(cam_idx) : 32'h8000_0000;
  assign ehi_we_o  = is_rd_idx;
  assign ehi_new_o = {rd_vpn, {PAGE_BITS{1'b0}}};
  assign elo_we_o  = is_rd_idx;
  assign elo_new_o = lo_from_ent(ram_rd);

endmodule

// File: rtl/tlb_mmu_chk.sv
module tlb_mmu_chk
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES  = 32,
  parameter int unsigned RAND_LOW = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [2:0]                 fn_i,
  input logic [31:0]                vaddr_i,
  input logic [31:0]                paddr_o,
  input logic                       miss_kern_o,
  input logic                       miss_user_o,
  input logic                       invalid_o,
  input logic                       wprot_o,
  input logic                       idx_we_o,
  input logic [31:0]                idx_new_o,
  input logic                       ehi_we_o,
  input logic [31:0]                ehi_new_o,
  input logic                       elo_we_o,
  input logic [31:0]                elo_new_o,
  input logic [$clog2(ENTRIES)-1:0] victim_idx
);

  localparam int unsigned IDX_W = $clog2(ENTRIES);

  logic prev_map;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_map <= 1'b1;
    else        prev_map <= (fn_i == FN_MAP);
  end

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({miss_kern_o, miss_user_o, invalid_o, wprot_o})); // R3

  AST_DIRECT_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_i == FN_MAP && vaddr_i[31:30] == 2'b11) |=>
      (paddr_o == {2'b00, $past(vaddr_i[29:0])}) &&
      !miss_kern_o && !miss_user_o && !invalid_o && !wprot_o); // R4

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_i != FN_MAP && !prev_map) |=>
      $stable(paddr_o) && $stable(miss_kern_o) && $stable(miss_user_o) &&
      $stable(invalid_o) && $stable(wprot_o)); // R6

  AST_SEARCH_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_i == FN_SEARCH) |->
      idx_we_o && !ehi_we_o && !elo_we_o &&
      (idx_new_o[31] ? (idx_new_o[30:0] == 31'd0) : (idx_new_o < 32'(ENTRIES)))); // R7

  AST_VICTIM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    victim_idx >= IDX_W'(RAND_LOW)); // R9

  AST_VICTIM_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_i != FN_MAP) |=> $stable(victim_idx)); // R9

  AST_READ_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_i == FN_RD_IDX) |->
      ehi_we_o && elo_we_o && !idx_we_o &&
      (ehi_new_o[11:0] == 12'd0) && (elo_new_o[11:2] == 10'd0)); // R10

  AST_QUIET_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_i != FN_SEARCH && fn_i != FN_RD_IDX) |->
      !idx_we_o && !ehi_we_o && !elo_we_o); // R11

endmodule

bind tlb_mmu tlb_mmu_chk #(.ENTRIES(ENTRIES), .RAND_LOW(RAND_LOW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fn_i        (fn_i),
  .vaddr_i     (vaddr_i),
  .paddr_o     (paddr_o),
  .miss_kern_o (miss_kern_o),
  .miss_user_o (miss_user_o),
  .invalid_o   (invalid_o),
  .wprot_o     (wprot_o),
  .idx_we_o    (idx_we_o),
  .idx_new_o   (idx_new_o),
  .ehi_we_o    (ehi_we_o),
  .ehi_new_o   (ehi_new_o),
  .elo_we_o    (elo_we_o),
  .elo_new_o   (elo_new_o),
  .victim_idx  (victim_idx)
);

// File: tb/tlb_mmu_bench.sv
module tlb_mmu_bench;
  import tlb_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [2:0]  fn;
  logic [31:0] vaddr, idx_old, ehi_old, elo_old;
  logic [31:0] paddr, idx_new, ehi_new, elo_new;
  logic        mk, mu, inv, wp, idx_we, ehi_we, elo_we;

  tlb_mmu u_tlb_mmu (
    .clk(clk), .rst_n(rst_n), .fn_i(fn), .vaddr_i(vaddr), .paddr_o(paddr),
    .miss_kern_o(mk), .miss_user_o(mu), .invalid_o(inv), .wprot_o(wp),
    .idx_old_i(idx_old), .idx_we_o(idx_we), .idx_new_o(idx_new),
    .ehi_old_i(ehi_old), .ehi_we_o(ehi_we), .ehi_new_o(ehi_new),
    .elo_old_i(elo_old), .elo_we_o(elo_we), .elo_new_o(elo_new)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // {vaddr, expected paddr, expected {kern miss, user miss, invalid, wprot}}
  localparam logic [67:0] MAP_VEC [0:11] = '{
    {32'h1000_0ABC, 32'h2A00_0ABC, 4'b0000},
    {32'h1000_1123, 32'h2A00_1123, 4'b0001},
    {32'h1000_3FFF, 32'h2A00_3FFF, 4'b0010},
    {32'h8001_4010, 32'h2A01_4010, 4'b0000},
    {32'h8001_F001, 32'h2A01_F001, 4'b0010},
    {32'h1000_2000, 32'h2A00_2000, 4'b0000},
    {32'h2345_6789, 32'h0000_0000, 4'b0100},
    {32'h9000_0004, 32'h0000_0000, 4'b1000},
    {32'hC000_1234, 32'h0000_1234, 4'b0000},
    {32'hFFFF_FFFC, 32'h3FFF_FFFC, 4'b0000},
    {32'h8000_0000, 32'h0000_0000, 4'b1000},
    {32'hBFFF_F000, 32'h0000_0000, 4'b1000}
  };

  function automatic logic [19:0] fill_vpn(input int i);
    return ((i >= 16) ? 20'h80000 : 20'h10000) + 20'(i);
  endfunction
  function automatic logic [31:0] fill_lo(input int i);
    return {20'h2A000 + 20'(i), 10'b0, (i % 2 == 0), (i % 4 != 3)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] f, input logic [31:0] va, input logic [31:0] ix,
                       input logic [31:0] eh, input logic [31:0] el);
    @(negedge clk);
    fn = f; vaddr = va; idx_old = ix; ehi_old = eh; elo_old = el;
  endtask

  // map, then one more cycle; result is sampled 2 ns into that cycle
  task automatic map_and_wait(input logic [31:0] va);
    drive(FN_MAP, va, 32'd0, 32'd0, 32'd0);
    drive(FN_NOP, va, 32'd0, 32'd0, 32'd0);
    #2;
  endtask

  function automatic logic [31:0] flags_now();
    return {28'd0, mk, mu, inv, wp};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; fn = FN_NOP;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fn = FN_NOP; vaddr = '0; idx_old = '0; ehi_old = '0; elo_old = '0;
    #1;
    chk("R1 paddr in reset", paddr, 32'd0);
    chk("R1 flags in reset", flags_now(), 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R1 paddr after reset", paddr, 32'd0);
    chk("R1 write enables after reset", {29'd0, idx_we, ehi_we, elo_we}, 32'd0);

    // R8: fill every entry through write-indexed
    for (int i = 0; i < 32; i++)
      drive(FN_WR_IDX, 32'd0, 32'(i), {fill_vpn(i), 12'h0}, fill_lo(i));

    // table walk: R2 hits, R3 misses, R4 bypass
    for (int k = 0; k < 12; k++) begin
      map_and_wait(MAP_VEC[k][67:36]);
      chk($sformatf("R2/R3/R4/R8 paddr row %0d", k), paddr, MAP_VEC[k][35:4]);
      chk($sformatf("R2/R3/R4 flags row %0d", k), flags_now(), {28'd0, MAP_VEC[k][3:0]});
    end

    // R6: result held across nops, entry rewrite and changed inputs
    map_and_wait(32'h1000_0ABC);
    drive(FN_NOP, 32'h1000_3000, 32'd9, 32'h1234_5000, 32'hFFFF_F003);
    drive(FN_WR_IDX, 32'h1000_1000, 32'd0, 32'h1000_0000, 32'h0BAD_0001);
    drive(FN_NOP, 32'h2222_2222, 32'd0, 32'd0, 32'd0);
    #2;
    chk("R6 paddr held", paddr, 32'h2A00_0ABC);
    chk("R6 flags held", flags_now(), 32'd0);

    // R11: undefined codes write nothing and leave the result alone
    drive(3'd6, 32'h1000_1123, 32'd12, 32'h4444_4000, 32'h0101_0003);
    #2;
    chk("R11 code 6 enables", {29'd0, idx_we, ehi_we, elo_we}, 32'd0);
    drive(3'd7, 32'h1000_1123, 32'd12, 32'h4444_4000, 32'h0101_0003);
    #2;
    chk("R11 code 7 enables", {29'd0, idx_we, ehi_we, elo_we}, 32'd0);
    drive(FN_SEARCH, 32'd0, 32'd0, 32'h4444_4000, 32'd0);
    #2;
    chk("R11 no entry written by code 7", idx_new, 32'h8000_0000);
    chk("R11 paddr unchanged", paddr, 32'h2A00_0ABC);

    // R7: search hit and miss
    drive(FN_SEARCH, 32'd0, 32'd0, 32'h8001_A000, 32'd0);
    #2;
    chk("R7 search hit we", {31'd0, idx_we}, 32'd1);
    chk("R7 search hit index", idx_new, 32'd26);
    drive(FN_SEARCH, 32'd0, 32'd0, 32'hDEAD_0000, 32'd0);
    #2;
    chk("R7 search miss", idx_new, 32'h8000_0000);

    // R5: duplicate tags, lowest entry wins
    drive(FN_WR_IDX, 32'd0, 32'd20, 32'h7777_7000, 32'h0BBB_B003);
    drive(FN_WR_IDX, 32'd0, 32'd7,  32'h7777_7000, 32'h0AAA_A003);
    map_and_wait(32'h7777_7456);
    chk("R5 map picks entry 7", paddr, 32'h0AAA_A456);
    drive(FN_SEARCH, 32'd0, 32'd0, 32'h7777_7000, 32'd0);
    #2;
    chk("R5 search picks entry 7", idx_new, 32'd7);

    // R10: read-indexed after index settled for a cycle
    drive(FN_NOP, 32'd0, 32'd5, 32'd0, 32'd0);
    drive(FN_RD_IDX, 32'd0, 32'd5, 32'd0, 32'd0);
    #2;
    chk("R10 enables", {29'd0, idx_we, ehi_we, elo_we}, 32'd3);
    chk("R10 entry-high", ehi_new, 32'h1000_5000);
    chk("R10 entry-low", elo_new, 32'h2A00_5001);

    // R1/R9: victim counter from reset
    do_reset();
    drive(FN_WR_RAND, 32'd0, 32'd0, 32'h5555_5000, 32'h1234_5003);
    drive(FN_SEARCH, 32'd0, 32'd0, 32'h5555_5000, 32'd0);
    #2;
    chk("R1/R9 first victim is 31", idx_new, 32'd31);
    for (int n = 0; n < 27; n++)
      drive(FN_MAP, 32'hC000_0000, 32'd0, 32'd0, 32'd0);
    drive(FN_WR_RAND, 32'd0, 32'd0, 32'h6666_6000, 32'h0000_1001);
    drive(FN_SEARCH, 32'd0, 32'd0, 32'h6666_6000, 32'd0);
    #2;
    chk("R9 victim after 27 maps is 4", idx_new, 32'd4);
    drive(FN_MAP, 32'hC000_0000, 32'd0, 32'd0, 32'd0);
    drive(FN_WR_RAND, 32'd0, 32'd0, 32'h9999_9000, 32'h0F0F_0003);
    drive(FN_SEARCH, 32'd0, 32'd0, 32'h9999_9000, 32'd0);
    #2;
    chk("R9 victim wraps to 31", idx_new, 32'd31);
    map_and_wait(32'h9999_9ABC);
    chk("R9 random entry maps", paddr, 32'h0F0F_0ABC);
    chk("R9 random entry flags", flags_now(), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule